// File: doc/BRIEF.md
# Hot-Swap Card Power and Reset Sequencer

This block sequences power and reset for a plug-in card that can be inserted while the host is running. It waits until the card is fully seated, the host has granted power, and the monitored host-side supplies are good. It then turns on the card's supply switches and holds the card in reset for a fixed number of clock cycles. Reset is released only once the monitored card-side supplies are also good.

The supply comparators sit outside this block and deliver one "above threshold" flag per rail. A select input chooses whether the 5 V rails take part in monitoring or only the 3.3 V rails count. A low pulse on the host reset input that is wide enough re-runs the card reset interval without touching the supply switches. All inputs are asynchronous to the block clock and pass through two-flop synchronisers before any decision is made.

Top module: `hotswap_seq`

## Requirements
- R1: While `rst_n` is low and after its release with no power grant, `gate_en`=0, `drv_on_n`=1, `card_rst`=1, `card_rst_n`=0, `card_pwr_ok`=0 and `sig_valid_n`=1.
- R2: The card counts as seated only while both `seat_a_n` and `seat_b_n` are low. With either one high, the gates stay off and reset stays asserted. A card pulled out while running has its gates turned off and its reset asserted within 4 cycles.
- R3: While `host_pwr_en` is low, `gate_en` is 0 and reset is asserted, whatever the other inputs are.
- R4: Power sequencing starts when `host_pwr_en` rises with all other conditions met. `gate_en` rises on the third clock edge after the input change. Reset stays asserted for exactly PURST_CYC cycles of good card supplies after that, and is then released.
- R5: `card_rst_n` is always the complement of `card_rst`.
- R6: Suppose `host_rst_n` is low for at least RST_MIN_CYC consecutive synchronised cycles while the card is running. Reset is then asserted for exactly PURST_CYC cycles and `gate_en` stays 1 throughout. A shorter low pulse has no effect.
- R7: With `sel_3v3_only`=1, `host_5v_ok` and `card_5v_ok` are ignored, so low values on them disturb neither the gates nor reset. With `sel_3v3_only`=0, the 5 V flags are monitored together with the 3.3 V flags.
- R8: When a monitored card-side flag goes low while the card is running, the following happens: `card_pwr_ok` falls, reset is asserted, and `gate_en` stays 1. Reset is held while the flag is low. After the flag recovers, the full PURST_CYC reset interval runs again.
- R9: When a monitored host-side flag goes low, `gate_en` falls and `sig_valid_n` goes high within 4 cycles.
- R10: `sig_valid_n` is low only when reset is released and `card_pwr_ok` is 1.
- R11: `drv_on_n` is always the complement of `gate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seat_a_n | input | 1 | First insertion-detect contact, low when seated |
| seat_b_n | input | 1 | Second insertion-detect contact, low when seated |
| host_pwr_en | input | 1 | Host grant for card power, active high |
| host_rst_n | input | 1 | Host reset request, active low, width filtered |
| sel_3v3_only | input | 1 | 1: monitor 3.3 V rails only; 0: monitor 3.3 V and 5 V rails |
| host_3v3_ok | input | 1 | Host 3.3 V rail above threshold |
| host_5v_ok | input | 1 | Host 5 V rail above threshold |
| card_3v3_ok | input | 1 | Card 3.3 V rail above threshold |
| card_5v_ok | input | 1 | Card 5 V rail above threshold |
| gate_en | output | 1 | Enable for the external supply-switch gate drivers |
| drv_on_n | output | 1 | Low while the gate drivers are enabled |
| card_pwr_ok | output | 1 | Card-side monitored supplies valid with gates on |
| sig_valid_n | output | 1 | Low when card power is valid and reset is released |
| card_rst_n | output | 1 | Card reset, active low |
| card_rst | output | 1 | Card reset, active high |

## Verification
The bench measures the power-up reset interval cycle by cycle. A counter that is off by one, or that fails to restart after a supply dip, shows up as a reset length different from PURST_CYC. It sends a host reset pulse one cycle short of the minimum width and another exactly at the minimum. A filter that is off by one would either reset the card on the short pulse or miss the long one. A design that lets the host reset fall through to the idle path would show `gate_en` dropping during the sequence. The bench also drives the 5 V flags low under both select settings. This catches a design that ignores the select input, which would either reset a 3.3 V-only card or miss a 5 V failure. Card removal and host-supply loss are each checked for a prompt gate shutdown.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POR  = 2'd1,
    ST_RUN  = 2'd2
  } hs_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hs_rst_filter.sv
module hs_rst_filter #(
  parameter int unsigned MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_in_n,
  output logic req
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_sat;

  assign cnt_sat = (cnt_q == CW'(MIN_CYC));
  assign req     = !rst_in_n && (cnt_q == CW'(MIN_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (rst_in_n)      cnt_d = '0;
    else if (!cnt_sat) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // One request per low period
  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_pkg::*;
#(
  parameter int unsigned PURST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inserted,
  input  logic pwr_en,
  input  logic host_ok,
  input  logic card_ok,
  input  logic rst_req,
  output logic gate_on,
  output logic rst_on
);
  localparam int unsigned CW = (PURST_CYC > 1) ? $clog2(PURST_CYC) : 1;

  hs_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          allow, cnt_done;

  assign allow    = inserted && pwr_en && host_ok;
  assign cnt_done = (cnt_q == CW'(PURST_CYC - 1));

  always_comb begin
    state_d = state_q;
    if (!allow) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_POR;
        ST_POR:  if (card_ok && !rst_req && cnt_done) state_d = ST_RUN;
        ST_RUN:  if (!card_ok || rst_req) state_d = ST_POR;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (state_q != ST_POR || !card_ok || rst_req) cnt_d = '0;
    else                                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_on = (state_q != ST_IDLE);
  assign rst_on  = (state_q != ST_RUN);

  assert_remove_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inserted |=> (state_q == ST_IDLE));
  assert_pwr_off_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (state_q == ST_IDLE));
  assert_host_fail_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ok |=> (state_q == ST_IDLE));
  assert_release_via_por_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_RUN) |-> ($past(state_q) == ST_POR));
  assert_hrst_keeps_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && rst_req && allow) |=> (state_q == ST_POR));
  assert_card_drop_por_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !card_ok && allow) |=> (state_q == ST_POR));
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int unsigned PURST_CYC   = 16,
  parameter int unsigned RST_MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seat_a_n,
  input  logic seat_b_n,
  input  logic host_pwr_en,
  input  logic host_rst_n,
  input  logic sel_3v3_only,
  input  logic host_3v3_ok,
  input  logic host_5v_ok,
  input  logic card_3v3_ok,
  input  logic card_5v_ok,
  output logic gate_en,
  output logic drv_on_n,
  output logic card_pwr_ok,
  output logic sig_valid_n,
  output logic card_rst_n,
  output logic card_rst
);
  localparam int unsigned NIN = 9;
  localparam logic [NIN-1:0] SYNC_RST = 9'b111_000000;

  logic [NIN-1:0] raw, syn;
  logic s_seat_a_n, s_seat_b_n, s_hrst_n, s_pwr_en, s_sel;
  logic s_h3, s_h5, s_c3, s_c5;
  logic inserted, host_ok, card_ok, rst_req, gate_on, rst_on;

  assign raw = {seat_a_n, seat_b_n, host_rst_n, host_pwr_en, sel_3v3_only,
                host_3v3_ok, host_5v_ok, card_3v3_ok, card_5v_ok};

  hs_sync #(.W(NIN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {s_seat_a_n, s_seat_b_n, s_hrst_n, s_pwr_en, s_sel,
          s_h3, s_h5, s_c3, s_c5} = syn;

  assign inserted = !s_seat_a_n && !s_seat_b_n;
  assign host_ok  = s_h3 && (s_sel || s_h5);
  assign card_ok  = s_c3 && (s_sel || s_c5);

  hs_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .rst_in_n(s_hrst_n), .req(rst_req)
  );

  hs_seq_fsm #(.PURST_CYC(PURST_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .inserted(inserted), .pwr_en(s_pwr_en),
    .host_ok(host_ok), .card_ok(card_ok), .rst_req(rst_req),
    .gate_on(gate_on), .rst_on(rst_on)
  );

  assign gate_en     = gate_on;
  assign drv_on_n    = !gate_on;
  assign card_pwr_ok = gate_on && card_ok;
  assign card_rst    = rst_on;
  assign card_rst_n  = !rst_on;
  assign sig_valid_n = !(card_pwr_ok && !rst_on);

  assert_sig_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_valid_n |-> (card_rst_n && card_pwr_ok && gate_en));
endmodule

// File: tb/hotswap_seq_test.sv
module hotswap_seq_test;
  localparam int P = 16;
  localparam int M = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seat_a_n = 1'b0, seat_b_n = 1'b0, host_pwr_en = 1'b0, host_rst_n = 1'b1;
  logic sel_3v3_only = 1'b0, host_3v3_ok = 1'b1, host_5v_ok = 1'b1;
  logic card_3v3_ok = 1'b1, card_5v_ok = 1'b1;
  logic gate_en, drv_on_n, card_pwr_ok, sig_valid_n, card_rst_n, card_rst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hotswap_seq #(.PURST_CYC(P), .RST_MIN_CYC(M)) uut (
    .clk(clk), .rst_n(rst_n), .seat_a_n(seat_a_n), .seat_b_n(seat_b_n),
    .host_pwr_en(host_pwr_en), .host_rst_n(host_rst_n), .sel_3v3_only(sel_3v3_only),
    .host_3v3_ok(host_3v3_ok), .host_5v_ok(host_5v_ok), .card_3v3_ok(card_3v3_ok),
    .card_5v_ok(card_5v_ok), .gate_en(gate_en), .drv_on_n(drv_on_n),
    .card_pwr_ok(card_pwr_ok), .sig_valid_n(sig_valid_n), .card_rst_n(card_rst_n),
    .card_rst(card_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Output snapshot: gate, reset, signals-valid, plus the complement pairs
  task automatic chk_state(input string tag, input logic g, input logic r, input logic sv_n);
    chk({tag, " gate_en"}, int'(gate_en), int'(g));
    chk({tag, " card_rst"}, int'(card_rst), int'(r));
    chk({tag, " sig_valid_n"}, int'(sig_valid_n), int'(sv_n));
    chk("R5 card_rst_n complement", int'(card_rst_n), int'(!card_rst));
    chk("R11 drv_on_n complement", int'(drv_on_n), int'(!gate_en));
  endtask

  task automatic t_reset;
    step(1);
    chk_state("R1 in reset", 1'b0, 1'b1, 1'b1);
    chk("R1 card_pwr_ok in reset", int'(card_pwr_ok), 0);
    rst_n = 1'b1;
    step(10);
    chk_state("R3 no power grant", 1'b0, 1'b1, 1'b1);
    chk("R1 card_pwr_ok idle", int'(card_pwr_ok), 0);
  endtask

  task automatic t_powerup;
    int rcnt;
    host_pwr_en = 1'b1;
    step(2);
    chk("R4 gate still off before sync", int'(gate_en), 0);
    step(1);
    chk_state("R4 gate on, reset held", 1'b1, 1'b1, 1'b1);
    rcnt = 0;
    for (int i = 0; i < 3 * P; i++) begin
      if (card_rst) rcnt++;
      step(1);
    end
    chk("R4 power-up reset length", rcnt, P);
    chk_state("R10 running", 1'b1, 1'b0, 1'b0);
    chk("R10 card_pwr_ok running", int'(card_pwr_ok), 1);
  endtask

  task automatic t_hrst_short;
    int rcnt;
    host_rst_n = 1'b0;
    step(M - 1);
    host_rst_n = 1'b1;
    rcnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (card_rst) rcnt++;
    end
    chk("R6 short host reset ignored", rcnt, 0);
  endtask

  task automatic t_hrst_long;
    int rcnt, gl;
    host_rst_n = 1'b0;
    step(M);
    host_rst_n = 1'b1;
    rcnt = 0;
    gl = 0;
    for (int i = 0; i < P + 20; i++) begin
      step(1);
      if (card_rst) rcnt++;
      if (!gate_en) gl++;
    end
    chk("R6 host reset length", rcnt, P);
    chk("R6 gate stays on", gl, 0);
    chk_state("R6 back to run", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sel;
    sel_3v3_only = 1'b1;
    step(4);
    card_5v_ok = 1'b0;
    host_5v_ok = 1'b0;
    step(10);
    chk_state("R7 5V flags ignored", 1'b1, 1'b0, 1'b0);
    chk("R7 card_pwr_ok kept", int'(card_pwr_ok), 1);
    card_5v_ok = 1'b1;
    host_5v_ok = 1'b1;
    step(4);
    sel_3v3_only = 1'b0;
    step(4);
  endtask

  task automatic t_card_drop;
    int rcnt;
    card_5v_ok = 1'b0;
    step(4);
    chk_state("R8 card 5V drop", 1'b1, 1'b1, 1'b1);
    chk("R8 card_pwr_ok low", int'(card_pwr_ok), 0);
    step(20);
    chk("R8 reset held while low", int'(card_rst), 1);
    card_5v_ok = 1'b1;
    rcnt = 0;
    for (int i = 0; i < P + 10; i++) begin
      step(1);
      if (card_rst) rcnt++;
    end
    chk("R8 reset rerun after recovery", rcnt, P + 1);
    chk_state("R8 recovered", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_host_drop;
    host_5v_ok = 1'b0;
    step(4);
    chk_state("R9 host 5V drop", 1'b0, 1'b1, 1'b1);
    host_5v_ok = 1'b1;
    step(P + 8);
    chk_state("R9 recover after 5V", 1'b1, 1'b0, 1'b0);
    host_3v3_ok = 1'b0;
    step(4);
    chk_state("R9 host 3V3 drop", 1'b0, 1'b1, 1'b1);
    host_3v3_ok = 1'b1;
    step(P + 8);
  endtask

  task automatic t_removal;
    seat_b_n = 1'b1;
    step(4);
    chk_state("R2 card removed", 1'b0, 1'b1, 1'b1);
    step(20);
    chk("R2 one contact open stays off", int'(gate_en), 0);
    seat_b_n = 1'b0;
    step(P + 8);
    chk_state("R2 reinserted", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_pwr_off;
    host_pwr_en = 1'b0;
    step(4);
    chk_state("R3 power grant withdrawn", 1'b0, 1'b1, 1'b1);
    step(10);
    chk("R3 stays off", int'(gate_en), 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_hrst_short();
    t_hrst_long();
    t_sel();
    t_card_drop();
    t_host_drop();
    t_removal();
    t_pwr_off();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule